// File: doc/BRIEF.md
# Direct-Page Word Step Unit

This unit adds one to, or subtracts one from, a 16-bit little-endian word kept in two neighbouring bytes of the direct page. It has only an 8-bit data bus, so it works through five bus cycles in a fixed order. It fetches the operand offset from the program stream, reads the low byte and steps it, and writes the low byte back. Only after that write does it read the high byte, fold it into the running value, and write the high byte. The running value is held at full word width, so a carry or borrow out of the low byte reaches the high byte without a separate carry flag.

An upstream decoder pulses `go` with the opcode and the current program address. While the unit is busy it owns the bus. When the last write completes it reports negative and zero flags for the whole 16-bit result, together with a one-cycle `done` pulse.

Top module: `dp_word_step`

## Requirements
- R1: After reset `busy`, `done`, `flag_n` and `flag_z` are 0, and neither `bus_rd` nor `bus_wr` is asserted.
- R2: `go` with opcode 0x3A starts an increment and `go` with opcode 0x1A starts a decrement. `go` with any other opcode causes no bus activity and leaves `busy` low, the flags and memory unchanged.
- R3: The five cycles after an accepted `go` are, in order: a read at `pc`, a read at `{dp_page, off}`, a write of the low result byte to `{dp_page, off}`, a read at `{dp_page, off+1}`, and a write of the high result byte to `{dp_page, off+1}`. Here `off` is the byte returned by the first read. At most one of `bus_rd` and `bus_wr` is high in any cycle.
- R4: The offset advance wraps inside the 8-bit page: offset 0xFF is followed by offset 0x00 with the same `dp_page`. No access leaves the page.
- R5: A carry out of the low byte on increment, or a borrow on decrement, changes the high byte. For example, 0x00FF+1 gives 0x0100, 0x0100-1 gives 0x00FF, and 0xFFFF and 0x0000 wrap into each other.
- R6: `flag_n` equals bit 15 of the 16-bit result and `flag_z` is 1 exactly when the whole 16-bit result is zero. Both take their new values in the same cycle as `done` and hold their values at all other times.
- R7: `done` is a single-cycle pulse, high in the sixth cycle after the clock edge that accepts `go`. `go` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| go | input | 1 | Start request, sampled while idle |
| opcode | input | 8 | Operation code presented with `go` |
| pc | input | 16 | Address of the offset byte |
| dp_page | input | 8 | High address byte of the direct page |
| bus_addr | output | 16 | Bus address |
| bus_rd | output | 1 | Read strobe; data returned in the same cycle |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| flag_n | output | 1 | Negative flag of the last result |
| flag_z | output | 1 | Zero flag of the last result |

## Verification
Counting from the edge that accepts `go`, the bus strobes occupy cycles one to five. The low-byte write lands in memory before the high-byte read in cycle four. `done` and both flags become visible in cycle six. The bench drives `go` on a falling edge and samples every output on falling edges. It logs each strobe into a trace with its cycle order, and it requires `done` to be low on the first five falling edges and high on the sixth. Memory contents are compared only after `done`, so the comparison includes both write-backs.

// File: rtl/dp_word_step_pkg.sv
package dp_word_step_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FETCH = 3'd1,
    ST_RDLO  = 3'd2,
    ST_WRLO  = 3'd3,
    ST_RDHI  = 3'd4,
    ST_WRHI  = 3'd5
  } step_t;

  // Low byte widened before stepping so carry/borrow survives into the upper half
  function automatic logic [WORD_W-1:0] low_step(input logic [BYTE_W-1:0] lo,
                                                 input logic dec);
    logic [WORD_W-1:0] widened;
    widened = {{BYTE_W{1'b0}}, lo};
    return dec ? widened - WORD_W'(1) : widened + WORD_W'(1);
  endfunction

  // Add the high byte in its word position; any pending carry/borrow merges here
  function automatic logic [WORD_W-1:0] merge_high(input logic [WORD_W-1:0] part,
                                                   input logic [BYTE_W-1:0] hi);
    return part + {hi, {BYTE_W{1'b0}}};
  endfunction
endpackage

// File: rtl/dp_word_step_seq.sv
module dp_word_step_seq
  import dp_word_step_pkg::*;
#(
  parameter logic [BYTE_W-1:0] OP_INC = 8'h3A,
  parameter logic [BYTE_W-1:0] OP_DEC = 8'h1A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [BYTE_W-1:0] opcode,
  output step_t             st,
  output logic              dec,
  output logic              accept
);
  step_t st_nx;
  logic  op_known;

  assign op_known = (opcode == OP_INC) || (opcode == OP_DEC);
  assign accept   = go && (st == ST_IDLE) && op_known;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE:  if (accept) st_nx = ST_FETCH;
      ST_FETCH: st_nx = ST_RDLO;
      ST_RDLO:  st_nx = ST_WRLO;
      ST_WRLO:  st_nx = ST_RDHI;
      ST_RDHI:  st_nx = ST_WRHI;
      ST_WRHI:  st_nx = ST_IDLE;
      default:  st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      dec <= 1'b0;
    end else begin
      st <= st_nx;
      if (accept) dec <= (opcode == OP_DEC);
    end
  end

  // R2: an accepted start always enters the fetch step next
  assert_accept_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (st == ST_FETCH));

  // R3: once started the sequence advances every cycle, never stalls
  assert_no_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE) |=> (st != $past(st)));

  // R7: start requests during a sequence do not alter the direction
  assert_dir_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE) |=> $stable(dec));
endmodule

// File: rtl/dp_word_step_path.sv
module dp_word_step_path
  import dp_word_step_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  step_t             st,
  input  logic              dec,
  input  logic [BYTE_W-1:0] rdata,
  output logic [BYTE_W-1:0] off,
  output logic [WORD_W-1:0] part
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off  <= '0;
      part <= '0;
    end else begin
      unique case (st)
        ST_FETCH: off  <= rdata;
        ST_RDLO:  part <= low_step(rdata, dec);
        ST_WRLO:  off  <= off + BYTE_W'(1);  // wraps inside the page
        ST_RDHI:  part <= merge_high(part, rdata);
        default: ;
      endcase
    end
  end

  // R4: offset advances by exactly one, modulo the page size, after the low write
  assert_page_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WRLO) |=> (off == BYTE_W'($past(off) + 1'b1)));

  // R3: the offset is not disturbed between the advance and the high write
  assert_off_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RDHI) |=> $stable(off));
endmodule

// File: rtl/dp_word_step_flags.sv
module dp_word_step_flags
  import dp_word_step_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  step_t             st,
  input  logic [WORD_W-1:0] part,
  output logic              flag_n,
  output logic              flag_z,
  output logic              done
);
  logic fin;
  assign fin = (st == ST_WRHI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_n <= 1'b0;
      flag_z <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= fin;
      if (fin) begin
        flag_n <= part[WORD_W-1];
        flag_z <= (part == '0);
      end
    end
  end

  // R6: flags move only at the end of a sequence
  assert_flags_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !fin |=> ($stable(flag_n) && $stable(flag_z)));

  // R6: a zero result can never look negative
  assert_flag_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_z |-> !flag_n);

  // R7: completion is a single-cycle pulse
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/dp_word_step.sv
module dp_word_step
  import dp_word_step_pkg::*;
#(
  parameter logic [7:0] OP_INC = 8'h3A,
  parameter logic [7:0] OP_DEC = 8'h1A
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic [7:0]  opcode,
  input  logic [15:0] pc,
  input  logic [7:0]  dp_page,
  output logic [15:0] bus_addr,
  output logic        bus_rd,
  output logic        bus_wr,
  output logic [7:0]  bus_wdata,
  input  logic [7:0]  bus_rdata,
  output logic        busy,
  output logic        done,
  output logic        flag_n,
  output logic        flag_z
);
  step_t             st;
  logic              dec;
  logic              accept;
  logic [BYTE_W-1:0] off;
  logic [WORD_W-1:0] part;

  dp_word_step_seq #(.OP_INC(OP_INC), .OP_DEC(OP_DEC)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .opcode(opcode),
    .st(st), .dec(dec), .accept(accept)
  );

  dp_word_step_path u_path (
    .clk(clk), .rst_n(rst_n), .st(st), .dec(dec), .rdata(bus_rdata),
    .off(off), .part(part)
  );

  dp_word_step_flags u_flags (
    .clk(clk), .rst_n(rst_n), .st(st), .part(part),
    .flag_n(flag_n), .flag_z(flag_z), .done(done)
  );

  assign busy = (st != ST_IDLE);

  always_comb begin
    bus_rd    = 1'b0;
    bus_wr    = 1'b0;
    bus_addr  = {dp_page, off};
    bus_wdata = '0;
    unique case (st)
      ST_FETCH: begin bus_rd = 1'b1; bus_addr = pc; end
      ST_RDLO:  bus_rd = 1'b1;
      ST_WRLO:  begin bus_wr = 1'b1; bus_wdata = part[BYTE_W-1:0]; end
      ST_RDHI:  bus_rd = 1'b1;
      ST_WRHI:  begin bus_wr = 1'b1; bus_wdata = part[WORD_W-1:BYTE_W]; end
      default: ;
    endcase
  end

  // R2: idle unit leaves the bus alone
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_rd && !bus_wr));

  // R3: never a read and a write together
  assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_rd, bus_wr}));

  // R3: a read always follows a low-byte write at the same page
  assert_read_after_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (st == ST_WRLO)) |=> (bus_rd && (bus_addr[15:8] == dp_page)));

  // R7: completion arrives right after the high write
  assert_done_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WRHI) |=> (done && !busy));
endmodule

// File: tb/dp_word_step_tb.sv
`timescale 1ns/1ps
module dp_word_step_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        go = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [15:0] pc = 16'h0000;
  logic [7:0]  dp_page = 8'h01;
  logic [15:0] bus_addr;
  logic        bus_rd, bus_wr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic        busy, done, flag_n, flag_z;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;  // 250 MHz

  dp_word_step dut_i (
    .clk(clk), .rst_n(rst_n), .go(go), .opcode(opcode), .pc(pc), .dp_page(dp_page),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .busy(busy), .done(done), .flag_n(flag_n), .flag_z(flag_z)
  );

  // memory: program bytes at 0x0000.., direct page 0x01 at index 256..511
  logic [7:0] mem [0:511];
  assign bus_rdata = mem[bus_addr[8:0]];
  always @(posedge clk) if (bus_wr) mem[bus_addr[8:0]] <= bus_wdata;

  // bus trace recorded on falling edges
  int         tr_n = 0;
  logic       tr_w [0:15];
  logic [15:0] tr_a [0:15];
  int         off_page = 0;
  always @(negedge clk) begin
    if (bus_rd || bus_wr) begin
      if (tr_n < 16) begin tr_w[tr_n] = bus_wr; tr_a[tr_n] = bus_addr; end
      tr_n++;
      if (bus_wr && bus_addr[15:8] != dp_page) off_page++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {op, off, lo, hi, exp_lo, exp_hi, 6'b0 n z}
  localparam int NV = 8;
  localparam logic [55:0] VEC [NV] = '{
    {8'h3A, 8'h10, 8'hFF, 8'h00, 8'h00, 8'h01, 8'h00},
    {8'h1A, 8'h20, 8'h00, 8'h01, 8'hFF, 8'h00, 8'h00},
    {8'h3A, 8'h30, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'h01},
    {8'h1A, 8'h40, 8'h00, 8'h00, 8'hFF, 8'hFF, 8'h02},
    {8'h3A, 8'h50, 8'h34, 8'h12, 8'h35, 8'h12, 8'h00},
    {8'h1A, 8'h60, 8'h01, 8'h00, 8'h00, 8'h00, 8'h01},
    {8'h3A, 8'h70, 8'hFF, 8'h7F, 8'h00, 8'h80, 8'h02},
    {8'h3A, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'h01, 8'h00}
  };

  // pulse go for one cycle, then count cycles until done; returns cycle index
  task automatic launch(input logic [7:0] op, input logic [15:0] addr, output int at);
    at = -1;
    tr_n = 0;
    opcode = op; pc = addr; go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    for (int c = 1; c <= 10; c++) begin
      if (done && at < 0) at = c;
      if (c < 10) @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    int at;
    int seen;
    logic [7:0] hi_off;
    for (int i = 0; i < 512; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 flags", {flag_n, flag_z}, 0);
    chk("R1 strobes", {bus_rd, bus_wr}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [7:0] op, off, lo, hi, elo, ehi, nz;
      {op, off, lo, hi, elo, ehi, nz} = VEC[v];
      hi_off = off + 8'h01;
      mem[v] = off;
      mem[256 + off] = lo;
      mem[256 + hi_off] = hi;
      launch(op, 16'(v), at);
      // R7 done in cycle six
      chk("R7 done cycle", at, 6);
      // R2/R5 result bytes
      chk("R5 low byte", mem[256 + off], elo);
      chk("R5 high byte", mem[256 + hi_off], ehi);
      // R6 flags
      chk("R6 flags", {flag_n, flag_z}, nz[1:0]);
      // R3/R4 bus order
      chk("R3 access count", tr_n, 5);
      chk("R3 order", {tr_w[0], tr_w[1], tr_w[2], tr_w[3], tr_w[4]}, 5'b00101);
      chk("R3 fetch addr", tr_a[0], 16'(v));
      chk("R4 low addr", {tr_a[1], tr_a[2]}, {8'h01, off, 8'h01, off});
      chk("R4 high addr", {tr_a[3], tr_a[4]}, {8'h01, hi_off, 8'h01, hi_off});
    end
    chk("R4 no write outside page", off_page, 0);

    // R2: unknown opcode ignored, flags held (last vector left n=0 z=0)
    mem[20] = 8'h80; mem[256 + 8'h80] = 8'h55; mem[256 + 8'h81] = 8'h66;
    launch(8'hBC, 16'd20, at);
    chk("R2 ignored no done", at, -1);
    chk("R2 ignored no bus", tr_n, 0);
    chk("R2 ignored memory", {mem[256 + 8'h80], mem[256 + 8'h81]}, 16'h6655 ^ 16'h3333);
    chk("R6 flags held", {flag_n, flag_z}, 2'b00);

    // R7: go while busy is ignored; single update
    mem[21] = 8'h90; mem[256 + 8'h90] = 8'h10; mem[256 + 8'h91] = 8'h00;
    tr_n = 0;
    opcode = 8'h3A; pc = 16'd21; go = 1'b1;
    @(negedge clk);
    @(negedge clk);  // go still high while busy
    go = 1'b0;
    seen = 0;
    for (int c = 0; c < 12; c++) begin
      if (done) seen++;
      @(negedge clk);
    end
    chk("R7 one done", seen, 1);
    chk("R7 single increment", mem[256 + 8'h90], 8'h11);
    chk("R7 access count", tr_n, 5);

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule